// File: doc/BRIEF.md
# Push-Button Wake and Reset Timer

This block watches an active-low push-button and measures how long it stays pressed. It cleans up the raw input with a two-flop synchronizer and a debounce filter. The hold timer counts in slow ticks derived from the system clock. A press that is held past a programmable wake threshold raises a wake event. A press held past a longer programmable reset threshold raises a reset event. Each event sends a fixed 128 µs notification pulse to the host and sets a sticky status flag. The flag stays set until the host reads the status register.

A reset event drives the reset output for a programmable time. When that time ends, the block issues a one-cycle recovery request. The request depends on the supply state and a mode bit:
- With valid input power, it asks to resume the previous state, and to re-enable the system rail if that rail was off.
- With only the battery present, it asks for ship mode or high-impedance mode.

The button is honoured only under the supply qualifiers. Reset fires at most once per press.

Top module: `pbtn_ctrl`

## Requirements
- R1: The button is honoured only while `bat_ok` is 1, or while `vin_ok` and `chg_en` are both 1. Otherwise the hold timer is held at zero and no event occurs.
- R2: The button passes through a two-flop synchronizer. A change of level is accepted only after it has been stable for `DB_CYC` consecutive synchronized cycles. Shorter glitches have no effect.
- R3: The hold time counts ticks of `TICK_CYC` cycles each. When it reaches `WAKE_BASE << wake_sel` ticks, `stat_wake` is set and `irq` goes high for 128 µs, which is `CLK_HZ*128/10^6` cycles.
- R4: When the hold time reaches `RST_BASE << rst_sel` ticks, `stat_rst` is set, `irq` pulses as in R3, and `sys_rst` is high for `RST_UNIT_CYC << dur_sel` cycles. A new event restarts the `irq` pulse.
- R5: At most one reset event occurs per press. The reset is armed again only after the debounced button has been seen released.
- R6: With `rst_need_vin` = 1, a reset event also requires `vin_ok` = 1 at the moment the threshold is reached. Otherwise that press produces no reset.
- R7: `stat_wake` and `stat_rst` are sticky and are cleared by `stat_rd`. An event in the same cycle as `stat_rd` leaves its flag set.
- R8: In the first cycle after `sys_rst` falls, exactly one recovery request is pulsed for one cycle:
  - If `vin_ok` = 1, `rec_resume` is pulsed, and `rec_sys_on` is pulsed as well when `sys_off` = 1.
  - If `vin_ok` = 0, `rec_ship_req` is pulsed when `rec_mode_ship` = 1, otherwise `rec_hiz_req`.
- R9: If the reset threshold is not greater than the wake threshold, reset events are suppressed. The wake event still occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| btn_n | input | 1 | Raw push-button, low when pressed |
| bat_ok | input | 1 | Battery present qualifier |
| vin_ok | input | 1 | Input supply inside its valid window |
| chg_en | input | 1 | Charge enabled qualifier |
| wake_sel | input | 2 | Wake threshold code |
| rst_sel | input | 2 | Reset threshold code |
| dur_sel | input | 2 | Reset duration code |
| rst_need_vin | input | 1 | Reset also requires valid input supply |
| rec_mode_ship | input | 1 | Battery-only recovery: 1 ship, 0 high-impedance |
| sys_off | input | 1 | System rail currently disabled |
| stat_rd | input | 1 | Status register read strobe |
| irq | output | 1 | Notification pulse to host |
| sys_rst | output | 1 | Reset output, active high |
| stat_wake | output | 1 | Sticky wake flag |
| stat_rst | output | 1 | Sticky reset-fault flag |
| rec_resume | output | 1 | Recovery: resume prior state |
| rec_sys_on | output | 1 | Recovery: re-enable system rail |
| rec_ship_req | output | 1 | Recovery: enter ship mode |
| rec_hiz_req | output | 1 | Recovery: enter high-impedance mode |

## Verification
The bench tries the following input patterns:
- A glitch shorter than the debounce window, which separates filtered from raw behaviour.
- Long holds with wake and reset thresholds far apart, which show that the two events raise two distinct notification pulses.
- A very long hold followed by a re-press, which separates once-per-press from repeated firing.
- Holds under each combination of supply qualifiers and with the input-power requirement on and off, which show which supply states gate each event.
- Holds that end in each recovery branch.
- An equal threshold pair.
- A read strobe held high through an event, which shows whether set wins over clear.

// File: rtl/pb_pkg.sv
package pb_pkg;

  localparam int NOTIFY_US = 128;

  function automatic int us_to_cycles(input int hz, input int us);
    return int'((longint'(hz) * longint'(us)) / 64'd1000000);
  endfunction

  typedef struct packed {
    logic resume;
    logic sys_on;
    logic ship;
    logic hiz;
  } rec_t;

endpackage

// File: rtl/pb_filter.sv
module pb_filter #(
  parameter int DB_CYC = 250_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n,
  output logic held
);
  localparam int DW = $clog2(DB_CYC + 1);

  logic          s1_q, s2_q, db_q;
  logic          s1_d, s2_d, db_d;
  logic [DW-1:0] cnt_q, cnt_d;

  always_comb begin
    s1_d  = ~btn_n;
    s2_d  = s1_q;
    db_d  = db_q;
    cnt_d = cnt_q;
    if (s2_q == db_q) begin
      cnt_d = '0;
    end else if (cnt_q == DW'(DB_CYC - 1)) begin
      db_d  = s2_q;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      db_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q  <= s1_d;
      s2_q  <= s2_d;
      db_q  <= db_d;
      cnt_q <= cnt_d;
    end
  end

  assign held = db_q;

  // R2: the filtered level only moves after a full run of differing samples
  a_r2_debounce: assert property (@(posedge clk) disable iff (!rst_n)
    (db_q != $past(db_q)) |-> ($past(cnt_q) == DW'(DB_CYC - 1) && cnt_q == '0));
endmodule

// File: rtl/pb_hold.sv
module pb_hold #(
  parameter int TICK_CYC  = 1_250_000,
  parameter int HOLD_W    = 16,
  parameter int WAKE_BASE = 50,
  parameter int RST_BASE  = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       held,
  input  logic       qual,
  input  logic       vin_ok,
  input  logic       need_vin,
  input  logic [1:0] wake_sel,
  input  logic [1:0] rst_sel,
  input  logic       rst_idle,
  output logic       wake_ev,
  output logic       rst_ev
);
  localparam int TW    = $clog2(TICK_CYC);
  localparam int THR_W = HOLD_W + 4;

  logic [TW-1:0]     tcnt_q, tcnt_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              armed_q, armed_d;
  logic              active, last, fire;
  logic [THR_W-1:0]  wake_thr, rst_thr, hold_nx;

  always_comb begin
    wake_thr = THR_W'(WAKE_BASE) << wake_sel;
    rst_thr  = THR_W'(RST_BASE) << rst_sel;
    hold_nx  = THR_W'(hold_q) + 1'b1;
    active   = held & qual;
    last     = (tcnt_q == TW'(TICK_CYC - 1));
    fire     = active & last & (hold_q != '1);
    wake_ev  = fire & (hold_nx == wake_thr);
    rst_ev   = fire & (hold_nx == rst_thr) & armed_q & (rst_thr > wake_thr)
             & (~need_vin | vin_ok) & rst_idle;

    tcnt_d = tcnt_q;
    hold_d = hold_q;
    if (!active) begin
      tcnt_d = '0;
      hold_d = '0;
    end else if (last) begin
      tcnt_d = '0;
      if (hold_q != '1) hold_d = hold_q + 1'b1;
    end else begin
      tcnt_d = tcnt_q + 1'b1;
    end

    armed_d = armed_q;
    if (rst_ev)     armed_d = 1'b0;
    else if (!held) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q  <= '0;
      hold_q  <= '0;
      armed_q <= 1'b1;
    end else begin
      tcnt_q  <= tcnt_d;
      hold_q  <= hold_d;
      armed_q <= armed_d;
    end
  end

  // R1: an unqualified cycle leaves the hold timer empty
  a_r1_unqual: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> (hold_q == '0));
  // R5: after a reset event no second one is possible until a release
  a_r5_once: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ev && held) |=> !rst_ev);
endmodule

// File: rtl/pb_event.sv
module pb_event
  import pb_pkg::*;
#(
  parameter int NOTIFY_CYC   = 16_000,
  parameter int RST_UNIT_CYC = 50_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wake_ev,
  input  logic       rst_ev,
  input  logic       stat_rd,
  input  logic       vin_ok,
  input  logic       sys_off,
  input  logic       mode_ship,
  input  logic [1:0] dur_sel,
  output logic       irq,
  output logic       sys_rst,
  output logic [1:0] stat,
  output rec_t       rec,
  output logic       rst_idle
);
  localparam int NW = $clog2(NOTIFY_CYC + 1);
  localparam int RW = $clog2(RST_UNIT_CYC * 8 + 1);

  logic [NW-1:0] ncnt_q, ncnt_d;
  logic [RW-1:0] rcnt_q, rcnt_d;
  logic [1:0]    stat_q, stat_d;
  rec_t          rec_q, rec_d;

  always_comb begin
    if (wake_ev || rst_ev)  ncnt_d = NW'(NOTIFY_CYC);
    else if (ncnt_q != '0)  ncnt_d = ncnt_q - 1'b1;
    else                    ncnt_d = ncnt_q;

    if (rst_ev)             rcnt_d = RW'(RST_UNIT_CYC) << dur_sel;
    else if (rcnt_q != '0)  rcnt_d = rcnt_q - 1'b1;
    else                    rcnt_d = rcnt_q;

    rec_d = '0;
    if (rcnt_q == RW'(1)) begin
      if (vin_ok) begin
        rec_d.resume = 1'b1;
        rec_d.sys_on = sys_off;
      end else begin
        rec_d.ship = mode_ship;
        rec_d.hiz  = ~mode_ship;
      end
    end

    stat_d[0] = wake_ev | (stat_q[0] & ~stat_rd);
    stat_d[1] = rst_ev  | (stat_q[1] & ~stat_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ncnt_q <= '0;
      rcnt_q <= '0;
      stat_q <= '0;
      rec_q  <= '0;
    end else begin
      ncnt_q <= ncnt_d;
      rcnt_q <= rcnt_d;
      stat_q <= stat_d;
      rec_q  <= rec_d;
    end
  end

  assign irq      = (ncnt_q != '0);
  assign sys_rst  = (rcnt_q != '0);
  assign rst_idle = (rcnt_q == '0);
  assign stat     = stat_q;
  assign rec      = rec_q;

  // R3: a notification pulse starts only after an event
  a_r3_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wake_ev || rst_ev));
  // R4: a reset event drives the reset output on the next cycle
  a_r4_rst_start: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ev |=> sys_rst);
  // R7: an event wins over a simultaneous read
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ev |=> stat[0]);
  // R8: at most one recovery branch, and only right after reset ends
  a_r8_rec_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rec.resume, rec.ship, rec.hiz}));
  a_r8_rec_after_rst: assert property (@(posedge clk) disable iff (!rst_n)
    (rec.resume || rec.ship || rec.hiz) |-> ($past(sys_rst) && !sys_rst));
endmodule

// File: rtl/pbtn_ctrl.sv
module pbtn_ctrl
  import pb_pkg::*;
#(
  parameter int CLK_HZ       = 125_000_000,
  parameter int DB_CYC       = 250_000,
  parameter int TICK_CYC     = 1_250_000,
  parameter int HOLD_W       = 16,
  parameter int WAKE_BASE    = 50,
  parameter int RST_BASE     = 400,
  parameter int RST_UNIT_CYC = 50_000_000
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       btn_n,
  input  logic       bat_ok,
  input  logic       vin_ok,
  input  logic       chg_en,
  input  logic [1:0] wake_sel,
  input  logic [1:0] rst_sel,
  input  logic [1:0] dur_sel,
  input  logic       rst_need_vin,
  input  logic       rec_mode_ship,
  input  logic       sys_off,
  input  logic       stat_rd,
  output logic       irq,
  output logic       sys_rst,
  output logic       stat_wake,
  output logic       stat_rst,
  output logic       rec_resume,
  output logic       rec_sys_on,
  output logic       rec_ship_req,
  output logic       rec_hiz_req
);
  localparam int NOTIFY_CYC = us_to_cycles(CLK_HZ, NOTIFY_US);

  logic       rs1_q, rs2_q;
  logic       held, qual, wake_ev, rst_ev, rst_idle;
  logic [1:0] stat;
  rec_t       rec;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  assign qual = bat_ok | (vin_ok & chg_en);

  pb_filter #(.DB_CYC(DB_CYC)) u_filter (
    .clk(clk), .rst_n(rs2_q), .btn_n(btn_n), .held(held)
  );

  pb_hold #(
    .TICK_CYC(TICK_CYC), .HOLD_W(HOLD_W),
    .WAKE_BASE(WAKE_BASE), .RST_BASE(RST_BASE)
  ) u_hold (
    .clk(clk), .rst_n(rs2_q), .held(held), .qual(qual), .vin_ok(vin_ok),
    .need_vin(rst_need_vin), .wake_sel(wake_sel), .rst_sel(rst_sel),
    .rst_idle(rst_idle), .wake_ev(wake_ev), .rst_ev(rst_ev)
  );

  pb_event #(.NOTIFY_CYC(NOTIFY_CYC), .RST_UNIT_CYC(RST_UNIT_CYC)) u_event (
    .clk(clk), .rst_n(rs2_q), .wake_ev(wake_ev), .rst_ev(rst_ev),
    .stat_rd(stat_rd), .vin_ok(vin_ok), .sys_off(sys_off),
    .mode_ship(rec_mode_ship), .dur_sel(dur_sel), .irq(irq),
    .sys_rst(sys_rst), .stat(stat), .rec(rec), .rst_idle(rst_idle)
  );

  assign stat_wake    = stat[0];
  assign stat_rst     = stat[1];
  assign rec_resume   = rec.resume;
  assign rec_sys_on   = rec.sys_on;
  assign rec_ship_req = rec.ship;
  assign rec_hiz_req  = rec.hiz;
endmodule

// File: tb/pbtn_ctrl_test.sv
`timescale 1ns/1ps
module pbtn_ctrl_test;
  // Scaled parameters keep runs short: notify = 128 cycles
  localparam int HZ = 1_000_000, DB = 4, TK = 8, HW = 6;
  localparam int WB = 2, RB = 4, RU = 32, NOT = 128, HMAX = 63;

  logic clk = 0, arst_n = 0, btn_n = 1, bat_ok = 0, vin_ok = 0, chg_en = 0;
  logic [1:0] wake_sel = 0, rst_sel = 0, dur_sel = 0;
  logic rst_need_vin = 0, rec_mode_ship = 0, sys_off = 0, stat_rd = 0;
  logic irq, sys_rst, stat_wake, stat_rst, rec_resume, rec_sys_on, rec_ship_req, rec_hiz_req;

  always #4 clk = ~clk;

  pbtn_ctrl #(.CLK_HZ(HZ), .DB_CYC(DB), .TICK_CYC(TK), .HOLD_W(HW),
              .WAKE_BASE(WB), .RST_BASE(RB), .RST_UNIT_CYC(RU)) uut (
    .clk(clk), .arst_n(arst_n), .btn_n(btn_n), .bat_ok(bat_ok), .vin_ok(vin_ok),
    .chg_en(chg_en), .wake_sel(wake_sel), .rst_sel(rst_sel), .dur_sel(dur_sel),
    .rst_need_vin(rst_need_vin), .rec_mode_ship(rec_mode_ship), .sys_off(sys_off),
    .stat_rd(stat_rd), .irq(irq), .sys_rst(sys_rst), .stat_wake(stat_wake),
    .stat_rst(stat_rst), .rec_resume(rec_resume), .rec_sys_on(rec_sys_on),
    .rec_ship_req(rec_ship_req), .rec_hiz_req(rec_hiz_req));

  int vectors = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_rs1 = 0, m_rs2 = 0, m_s1 = 0, m_s2 = 0, m_db = 0, m_dc = 0;
  int m_tc = 0, m_hold = 0, m_armed = 1, m_nc = 0, m_rc = 0, m_wf = 0, m_rf = 0;
  int m_res = 0, m_son = 0, m_shp = 0, m_hiz = 0;

  always @(posedge clk) begin
    int press, qual, active, fire, wt, rt, wev, rev;
    int n_db, n_dc, n_tc, n_hold, n_armed, n_nc, n_rc;
    if (!arst_n || m_rs2 == 0) begin
      m_rs2 = arst_n ? m_rs1 : 0;
      m_rs1 = arst_n ? 1 : 0;
      m_s1 = 0; m_s2 = 0; m_db = 0; m_dc = 0; m_tc = 0; m_hold = 0; m_armed = 1;
      m_nc = 0; m_rc = 0; m_wf = 0; m_rf = 0; m_res = 0; m_son = 0; m_shp = 0; m_hiz = 0;
    end else begin
      press = !btn_n;
      n_db = m_db; n_dc = m_dc;
      if (m_s2 == m_db) n_dc = 0;
      else if (m_dc == DB - 1) begin n_db = m_s2; n_dc = 0; end
      else n_dc = m_dc + 1;
      qual = bat_ok || (vin_ok && chg_en);
      active = m_db && qual;
      fire = active && m_tc == TK - 1 && m_hold != HMAX;
      wt = WB << wake_sel; rt = RB << rst_sel;
      wev = fire && (m_hold + 1 == wt);
      rev = fire && (m_hold + 1 == rt) && m_armed && rt > wt
            && (!rst_need_vin || vin_ok) && m_rc == 0;
      if (!active) begin n_tc = 0; n_hold = 0; end
      else if (m_tc == TK - 1) begin n_tc = 0; n_hold = (m_hold == HMAX) ? HMAX : m_hold + 1; end
      else begin n_tc = m_tc + 1; n_hold = m_hold; end
      n_armed = rev ? 0 : (!m_db ? 1 : m_armed);
      n_nc = (wev || rev) ? NOT : (m_nc > 0 ? m_nc - 1 : 0);
      n_rc = rev ? (RU << dur_sel) : (m_rc > 0 ? m_rc - 1 : 0);
      m_res = 0; m_son = 0; m_shp = 0; m_hiz = 0;
      if (m_rc == 1) begin
        if (vin_ok) begin m_res = 1; m_son = sys_off; end
        else begin m_shp = rec_mode_ship; m_hiz = !rec_mode_ship; end
      end
      m_wf = wev || (m_wf && !stat_rd);
      m_rf = rev || (m_rf && !stat_rd);
      m_s2 = m_s1; m_s1 = press; m_db = n_db; m_dc = n_dc;
      m_tc = n_tc; m_hold = n_hold; m_armed = n_armed; m_nc = n_nc; m_rc = n_rc;
    end
  end

  // event counters seen at the ports
  int c_irq = 0, c_rst = 0, c_rlen = 0, c_res = 0, c_son = 0, c_shp = 0, c_hiz = 0, c_wseen = 0;
  logic p_irq = 0, p_rst = 0;

  always @(negedge clk) begin
    logic [7:0] act, exp;
    if (!done) begin
      act = {irq, sys_rst, stat_rst, stat_wake, rec_resume, rec_sys_on, rec_ship_req, rec_hiz_req};
      exp = {m_nc != 0, m_rc != 0, m_rf != 0, m_wf != 0, m_res != 0, m_son != 0, m_shp != 0, m_hiz != 0};
      vectors++;
      if (act !== exp) begin
        errors++;
        $display("FAIL R3/R4/R7/R8 model compare t=%0t actual=%b expected=%b", $time, act, exp);
      end
      if (irq && !p_irq) c_irq++;
      if (sys_rst && !p_rst) c_rst++;
      if (sys_rst) c_rlen++;
      c_res += int'(rec_resume); c_son += int'(rec_sys_on);
      c_shp += int'(rec_ship_req); c_hiz += int'(rec_hiz_req);
      c_wseen += int'(stat_wake);
      p_irq = irq; p_rst = sys_rst;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_counts();
    c_irq = 0; c_rst = 0; c_rlen = 0; c_res = 0; c_son = 0; c_shp = 0; c_hiz = 0; c_wseen = 0;
  endtask

  task automatic press(input int n);
    btn_n = 0; cyc(n); btn_n = 1; cyc(450);
  endtask

  task automatic read_stat();
    stat_rd = 1; cyc(1); stat_rd = 0; cyc(1);
  endtask

  initial begin
    cyc(5); arst_n = 1; cyc(10);
    chk("R7 reset flags", int'({stat_rst, stat_wake}), 0);
    chk("R4 reset idle", int'({irq, sys_rst}), 0);

    // R2: glitch shorter than the debounce window
    bat_ok = 1; clr_counts();
    btn_n = 0; cyc(3); btn_n = 1; cyc(100);
    chk("R2 glitch irq", c_irq, 0);

    // R3/R4: wake at 2 ticks, reset at 32 ticks, battery only, ship
    wake_sel = 0; rst_sel = 3; dur_sel = 0; rec_mode_ship = 1; clr_counts();
    press(400);
    chk("R3 wake+reset irq pulses", c_irq, 2);
    chk("R3 wake flag", int'(stat_wake), 1);
    chk("R4 reset flag", int'(stat_rst), 1);
    chk("R4 reset count", c_rst, 1);
    chk("R4 reset length", c_rlen, RU);
    chk("R8 ship request", c_shp, 1);
    read_stat();
    chk("R7 read clears", int'({stat_rst, stat_wake}), 0);

    // R5: one reset per press, rearm after release
    dur_sel = 1; clr_counts();
    btn_n = 0; cyc(800); btn_n = 1; cyc(50);
    chk("R5 single reset per long hold", c_rst, 1);
    press(400);
    chk("R5 rearmed after release", c_rst, 2);
    chk("R4 reset length code1", c_rlen, 2 * RU * 2);
    read_stat();

    // R1: unqualified supply
    bat_ok = 0; vin_ok = 1; chg_en = 0; clr_counts();
    press(400);
    chk("R1 unqualified irq", c_irq, 0);
    chk("R1 unqualified flags", int'({stat_rst, stat_wake}), 0);

    // R1/R8: qualified by input supply with charge, resume plus rail on
    chg_en = 1; sys_off = 1; clr_counts();
    press(400);
    chk("R1 qualified reset", c_rst, 1);
    chk("R8 resume", c_res, 1);
    chk("R8 rail on", c_son, 1);
    chk("R8 no ship/hiz", c_shp + c_hiz, 0);
    sys_off = 0; read_stat();

    // R6: reset needs valid input supply
    rst_need_vin = 1; bat_ok = 1; vin_ok = 0; chg_en = 0; clr_counts();
    press(400);
    chk("R6 no reset without vin", c_rst, 0);
    chk("R6 wake still occurs", c_irq, 1);
    vin_ok = 1; clr_counts();
    press(400);
    chk("R6 reset with vin", c_rst, 1);
    rst_need_vin = 0; vin_ok = 0; read_stat();

    // R8: high-impedance branch
    rec_mode_ship = 0; clr_counts();
    press(400);
    chk("R8 hiz request", c_hiz, 1);
    chk("R8 no ship", c_shp, 0);
    read_stat();

    // R9: reset threshold equal to wake threshold (8 ticks each)
    wake_sel = 2; rst_sel = 1; clr_counts();
    press(400);
    chk("R9 reset suppressed", c_rst, 0);
    chk("R9 wake kept", int'(stat_wake), 1);
    read_stat();

    // R7: read strobe held through the wake event
    wake_sel = 0; rst_sel = 3; clr_counts();
    stat_rd = 1;
    btn_n = 0; cyc(100); btn_n = 1; cyc(200);
    stat_rd = 0; cyc(2);
    chk("R7 set wins over read", c_wseen, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule